// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port Memory

This block is an 18-Kbit synchronous memory. It holds 16 Kbit of data and 2 Kbit of parity as 512 rows of 36 bits. Each row has 32 data bits (row bits 31:0) and 4 parity bits (row bits 35:32). Two independent ports, A and B, reach the same rows. Each port has its own clock, synchronous output reset, enable, write enable, address, write data and read data. Each port's width is a parameter chosen from 1, 2, 4, 9, 18 and 36. A port narrower than a row sees the row as a set of lanes, so one port can write narrow words that the other port reads as wide ones, or the reverse.

Each port selects how its output behaves on a write cycle: it can return the old stored word, return the new word, or keep its previous value. Each port may add a pipeline register that delays its read data by one cycle. A parameter turns on a simple dual-port arrangement. In that arrangement port A only writes and port B only reads. When both ports write overlapping bits in the same cycle, the stored result is undefined, and users must avoid that case.

Top module: `mixed_aspect_dpram`

## Requirements
- R1: With no pipeline register, an enabled read captures address and enable on the rising edge, and the addressed word is on the data output right after that edge.
- R2: A port whose enable is low ignores its write enable. It changes no stored bit, and its data output keeps its value.
- R3: With the pipeline register selected, the port's data output is its latched read value delayed by exactly one more rising edge.
- R4: On an enabled write, the port's latched output becomes the stored word before the write in read-first mode (mode value 0). It becomes the written word in write-first mode (mode value 1). It keeps its previous value in no-change mode (mode value 2).
- R5: A port of width 1, 2, 4, 9, 18 or 36 has 32, 16, 8, 4, 2 or 1 lanes per row. Its address is {row[8:0], lane}, and lane 0 occupies the least significant data bits of the row. A port word places its data bits in the low positions and its parity bits above them.
- R6: In the 9-, 18- and 36-bit shapes, 1, 2 and 4 of the bits are parity. Lane l of a 9/18-bit port uses row parity bit l or bits 2l+1:2l. Ports of width 1, 2 and 4 never see or alter parity bits.
- R7: Both ports access the same stored bits whatever their widths. A read in the cycle in which the other port writes the same bits returns the contents from before that write.
- R8: In simple dual-port mode, port B's write enable is ignored and port A's data output stays zero. Port B's output holds in any cycle in which port A performs an enabled write.
- R9: While a port's reset is high at a rising edge, its latched output and pipeline register clear to zero. Stored contents are not changed.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous output reset |
| en_a | input | 1 | Port A operation enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | 9+log2(lanes A) | Port A address {row, lane} |
| din_a | input | WIDTH_A | Port A write word |
| dout_a | output | WIDTH_A | Port A read word |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous output reset |
| en_b | input | 1 | Port B operation enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | 9+log2(lanes B) | Port B address {row, lane} |
| din_b | input | WIDTH_B | Port B write word |
| dout_b | output | WIDTH_B | Port B read word |

## Verification
The assertions check the following on every cycle:
- the clearing of the outputs by reset;
- the output rule of each write mode;
- the hold of an idle port;
- read latency with and without the pipeline register;
- the silent write-only port and the held read port in simple dual-port mode.

Lane placement, parity visibility, sharing of bits between ports of different widths, and same-cycle reads of bits that the other port is writing all depend on stored contents. Only the bench's scenarios show these, comparing every output against a row-level model of the storage.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int ROWS      = 512;
    localparam int ROW_AW    = 9;
    localparam int ROW_DATA  = 32;
    localparam int ROW_PAR   = 4;
    localparam int ROW_BITS  = ROW_DATA + ROW_PAR;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wr_mode_e;

    function automatic int lanes_of(input int w);
        case (w)
            1:       return 32;
            2:       return 16;
            4:       return 8;
            9:       return 4;
            18:      return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int par_of(input int w);
        return (w >= 9) ? w / 9 : 0;
    endfunction

    function automatic int data_of(input int w);
        return w - par_of(w);
    endfunction

    function automatic int lane_bits(input int w);
        return $clog2(lanes_of(w));
    endfunction

    function automatic int addr_bits(input int w);
        return ROW_AW + lane_bits(w);
    endfunction

endpackage

// File: rtl/dpm_lane_map.sv
module dpm_lane_map #(
    parameter int W = 9
) (
    input  logic [dpm_pkg::ROW_BITS-1:0] row_bits,
    input  logic [5:0]                   lane,
    input  logic [W-1:0]                 wr_word,
    output logic [W-1:0]                 rd_word,
    output logic [dpm_pkg::ROW_BITS-1:0] merged
);
    localparam int DW = dpm_pkg::data_of(W);
    localparam int PW = dpm_pkg::par_of(W);

    always_comb begin
        rd_word = '0;
        merged  = row_bits;
        for (int i = 0; i < DW; i++) begin
            rd_word[i] = row_bits[6'(int'(lane) * DW + i)];
            merged[6'(int'(lane) * DW + i)] = wr_word[i];
        end
        for (int j = 0; j < PW; j++) begin
            rd_word[DW + j] = row_bits[6'(dpm_pkg::ROW_DATA + int'(lane) * PW + j)];
            merged[6'(dpm_pkg::ROW_DATA + int'(lane) * PW + j)] = wr_word[DW + j];
        end
    end
endmodule

// File: rtl/dpm_port.sv
module dpm_port #(
    parameter int               W         = 9,
    parameter dpm_pkg::wr_mode_e MODE     = dpm_pkg::WM_READ_FIRST,
    parameter bit               OREG      = 1'b0,
    parameter bit               CAN_WRITE = 1'b1,
    parameter bit               CAN_READ  = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                en,
    input  logic                                we,
    input  logic [dpm_pkg::addr_bits(W)-1:0]    addr,
    input  logic [W-1:0]                        din,
    output logic [W-1:0]                        dout,
    input  logic                                peer_busy,
    output logic [dpm_pkg::ROW_AW-1:0]          my_row,
    input  logic [dpm_pkg::ROW_AW-1:0]          peer_row,
    output logic [dpm_pkg::ROW_BITS-1:0]        own_at_peer,
    input  logic [dpm_pkg::ROW_BITS-1:0]        peer_at_own
);
    localparam int AW = dpm_pkg::addr_bits(W);
    localparam int LB = dpm_pkg::lane_bits(W);
    localparam bit READS_ON_WRITE = CAN_WRITE && CAN_READ;

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] pipe;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [dpm_pkg::ROW_BITS-1:0] bank [dpm_pkg::ROWS];
    logic [dpm_pkg::ROW_BITS-1:0] old_row;
    logic [dpm_pkg::ROW_BITS-1:0] merged;
    logic [W-1:0]                 rd_word;
    logic [5:0]                   lane;

    initial begin
        for (int r = 0; r < dpm_pkg::ROWS; r++) bank[r] = '0;
    end

    assign my_row = addr[AW-1:LB];

    generate
        if (LB > 0) begin : g_lane
            assign lane = 6'(addr[LB-1:0]);
        end else begin : g_nolane
            assign lane = '0;
        end
    endgenerate

    // logical row content is the XOR of both banks
    assign old_row     = bank[my_row] ^ peer_at_own;
    assign own_at_peer = bank[peer_row];

    dpm_lane_map #(.W(W)) i_lane_map (
        .row_bits (old_row),
        .lane     (lane),
        .wr_word  (din),
        .rd_word  (rd_word),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (en && we && CAN_WRITE) begin
            bank[my_row] <= merged ^ peer_at_own;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.pipe = st_q.lat;
        if (en && we && CAN_WRITE) begin
            if (CAN_READ) begin
                case (MODE)
                    dpm_pkg::WM_READ_FIRST:  st_d.lat = rd_word;
                    dpm_pkg::WM_WRITE_FIRST: st_d.lat = din;
                    default:                 st_d.lat = st_q.lat;
                endcase
            end
        end else if (en && CAN_READ && !peer_busy) begin
            st_d.lat = rd_word;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = OREG ? st_q.pipe : st_q.lat;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> dout == '0); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.lat)); // R2

    generate
        if (CAN_READ && !OREG) begin : g_rd_direct
            AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
                en && !(we && CAN_WRITE) && !peer_busy |=> dout == $past(rd_word)); // R1
        end
        if (CAN_READ && OREG) begin : g_rd_piped
            AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
                en && !(we && CAN_WRITE) && !peer_busy |=> ##1 dout == $past(rd_word, 2)); // R3
        end
        if (READS_ON_WRITE && MODE == dpm_pkg::WM_READ_FIRST) begin : g_rf
            AST_READ_FIRST_OLD: assert property (@(posedge clk) disable iff (rst)
                en && we |=> st_q.lat == $past(rd_word)); // R4
        end
        if (READS_ON_WRITE && MODE == dpm_pkg::WM_WRITE_FIRST && !OREG) begin : g_wf
            AST_WRITE_FIRST_NEW: assert property (@(posedge clk) disable iff (rst)
                en && we |=> dout == $past(din)); // R4
        end
        if (READS_ON_WRITE && MODE == dpm_pkg::WM_WRITE_FIRST && OREG) begin : g_wfp
            AST_WRITE_FIRST_NEW_PIPED: assert property (@(posedge clk) disable iff (rst)
                en && we |=> ##1 dout == $past(din, 2)); // R4
        end
        if (READS_ON_WRITE && MODE == dpm_pkg::WM_NO_CHANGE) begin : g_nc
            AST_NO_CHANGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
                en && we |=> $stable(st_q.lat)); // R4
        end
        if (!CAN_READ) begin : g_wonly
            AST_WRONLY_SILENT: assert property (@(posedge clk) disable iff (rst)
                en |=> dout == '0); // R8
        end
        if (!CAN_WRITE) begin : g_ronly
            AST_RONLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
                peer_busy |=> $stable(st_q.lat)); // R8
        end
    endgenerate
endmodule

// File: rtl/mixed_aspect_dpram.sv
module mixed_aspect_dpram #(
    parameter int                WIDTH_A   = 9,
    parameter int                WIDTH_B   = 36,
    parameter dpm_pkg::wr_mode_e MODE_A    = dpm_pkg::WM_READ_FIRST,
    parameter dpm_pkg::wr_mode_e MODE_B    = dpm_pkg::WM_WRITE_FIRST,
    parameter bit                OREG_A    = 1'b0,
    parameter bit                OREG_B    = 1'b1,
    parameter bit                SIMPLE_DP = 1'b0
) (
    input  logic                                   clk_a,
    input  logic                                   rst_a,
    input  logic                                   en_a,
    input  logic                                   we_a,
    input  logic [dpm_pkg::addr_bits(WIDTH_A)-1:0] addr_a,
    input  logic [WIDTH_A-1:0]                     din_a,
    output logic [WIDTH_A-1:0]                     dout_a,
    input  logic                                   clk_b,
    input  logic                                   rst_b,
    input  logic                                   en_b,
    input  logic                                   we_b,
    input  logic [dpm_pkg::addr_bits(WIDTH_B)-1:0] addr_b,
    input  logic [WIDTH_B-1:0]                     din_b,
    output logic [WIDTH_B-1:0]                     dout_b
);
    localparam bit A_READS  = !SIMPLE_DP;
    localparam bit B_WRITES = !SIMPLE_DP;

    logic [dpm_pkg::ROW_AW-1:0]   row_a, row_b;
    logic [dpm_pkg::ROW_BITS-1:0] bank_a_at_b, bank_b_at_a;
    logic                         busy_for_b;

    assign busy_for_b = SIMPLE_DP ? (en_a && we_a) : 1'b0;

    dpm_port #(
        .W(WIDTH_A), .MODE(MODE_A), .OREG(OREG_A),
        .CAN_WRITE(1'b1), .CAN_READ(A_READS)
    ) i_port_a (
        .clk         (clk_a),
        .rst         (rst_a),
        .en          (en_a),
        .we          (we_a),
        .addr        (addr_a),
        .din         (din_a),
        .dout        (dout_a),
        .peer_busy   (1'b0),
        .my_row      (row_a),
        .peer_row    (row_b),
        .own_at_peer (bank_a_at_b),
        .peer_at_own (bank_b_at_a)
    );

    dpm_port #(
        .W(WIDTH_B), .MODE(MODE_B), .OREG(OREG_B),
        .CAN_WRITE(B_WRITES), .CAN_READ(1'b1)
    ) i_port_b (
        .clk         (clk_b),
        .rst         (rst_b),
        .en          (en_b),
        .we          (we_b),
        .addr        (addr_b),
        .din         (din_b),
        .dout        (dout_b),
        .peer_busy   (busy_for_b),
        .my_row      (row_b),
        .peer_row    (row_a),
        .own_at_peer (bank_b_at_a),
        .peer_at_own (bank_a_at_b)
    );
endmodule

// File: tb/test_mixed_aspect_dpram.sv
module test_mixed_aspect_dpram;
    import dpm_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        en [3][2];
    logic        we [3][2];
    logic [13:0] ad [3][2];
    logic [35:0] di [3][2];

    logic [3:0]  q0a; logic [35:0] q0b;
    logic [8:0]  q1a; logic [17:0] q1b;
    logic [35:0] q2a; logic [8:0]  q2b;

    int       WID [3][2] = '{'{4, 36}, '{9, 18}, '{36, 9}};
    wr_mode_e MD  [3][2] = '{'{WM_READ_FIRST, WM_WRITE_FIRST},
                             '{WM_NO_CHANGE, WM_READ_FIRST},
                             '{WM_READ_FIRST, WM_READ_FIRST}};
    bit       ORG [3][2] = '{'{1'b0, 1'b1}, '{1'b1, 1'b0}, '{1'b0, 1'b0}};
    bit       SDPM [3]   = '{1'b0, 1'b0, 1'b1};

    logic [35:0] mdl [3][512];
    logic [35:0] lat [3][2];
    logic [35:0] pip [3][2];
    int checks = 0, errors = 0, flagged = 0;

    mixed_aspect_dpram #(.WIDTH_A(4), .WIDTH_B(36), .MODE_A(WM_READ_FIRST),
        .MODE_B(WM_WRITE_FIRST), .OREG_A(1'b0), .OREG_B(1'b1), .SIMPLE_DP(1'b0))
    i_mixed_aspect_dpram (
        .clk_a(clk), .rst_a(rst), .en_a(en[0][0]), .we_a(we[0][0]),
        .addr_a(ad[0][0][11:0]), .din_a(di[0][0][3:0]), .dout_a(q0a),
        .clk_b(clk), .rst_b(rst), .en_b(en[0][1]), .we_b(we[0][1]),
        .addr_b(ad[0][1][8:0]), .din_b(di[0][1]), .dout_b(q0b));

    mixed_aspect_dpram #(.WIDTH_A(9), .WIDTH_B(18), .MODE_A(WM_NO_CHANGE),
        .MODE_B(WM_READ_FIRST), .OREG_A(1'b1), .OREG_B(1'b0), .SIMPLE_DP(1'b0))
    i_mixed_aspect_dpram_nc (
        .clk_a(clk), .rst_a(rst), .en_a(en[1][0]), .we_a(we[1][0]),
        .addr_a(ad[1][0][10:0]), .din_a(di[1][0][8:0]), .dout_a(q1a),
        .clk_b(clk), .rst_b(rst), .en_b(en[1][1]), .we_b(we[1][1]),
        .addr_b(ad[1][1][9:0]), .din_b(di[1][1][17:0]), .dout_b(q1b));

    mixed_aspect_dpram #(.WIDTH_A(36), .WIDTH_B(9), .MODE_A(WM_READ_FIRST),
        .MODE_B(WM_READ_FIRST), .OREG_A(1'b0), .OREG_B(1'b0), .SIMPLE_DP(1'b1))
    i_mixed_aspect_dpram_sdp (
        .clk_a(clk), .rst_a(rst), .en_a(en[2][0]), .we_a(we[2][0]),
        .addr_a(ad[2][0][8:0]), .din_a(di[2][0]), .dout_a(q2a),
        .clk_b(clk), .rst_b(rst), .en_b(en[2][1]), .we_b(we[2][1]),
        .addr_b(ad[2][1][10:0]), .din_b(di[2][1][8:0]), .dout_b(q2b));

    function automatic int ln_of(input int w);
        return (w >= 9) ? 36 / w : 32 / w;
    endfunction
    function automatic int pw_of(input int w);
        return (w >= 9) ? w / 9 : 0;
    endfunction

    function automatic logic [35:0] take(input logic [35:0] r, input int w, input int lane);
        logic [35:0] v = '0;
        int dw = w - pw_of(w);
        for (int i = 0; i < dw; i++) v[i] = r[lane * dw + i];
        for (int j = 0; j < pw_of(w); j++) v[dw + j] = r[32 + lane * pw_of(w) + j];
        return v;
    endfunction

    function automatic logic [35:0] place(input logic [35:0] r, input int w, input int lane,
                                          input logic [35:0] v);
        logic [35:0] o = r;
        int dw = w - pw_of(w);
        for (int i = 0; i < dw; i++) o[lane * dw + i] = v[i];
        for (int j = 0; j < pw_of(w); j++) o[32 + lane * pw_of(w) + j] = v[dw + j];
        return o;
    endfunction

    function automatic logic [35:0] outp(input int k, input int p);
        case (k * 2 + p)
            0: return {32'b0, q0a};
            1: return q0b;
            2: return {27'b0, q1a};
            3: return {18'b0, q1b};
            4: return q2a;
            default: return {27'b0, q2b};
        endcase
    endfunction

    function automatic logic [35:0] wmask(input int w);
        return (w == 36) ? 36'hF_FFFF_FFFF : (36'h1 << w) - 36'h1;
    endfunction

    task automatic idle();
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 2; p++) begin
                en[k][p] = 1'b0; we[k][p] = 1'b0; ad[k][p] = '0; di[k][p] = '0;
            end
    endtask

    task automatic put(input int k, input int p, input bit e, input bit w, input int a,
                       input logic [35:0] d);
        en[k][p] = e; we[k][p] = w; ad[k][p] = 14'(a); di[k][p] = d & wmask(WID[k][p]);
    endtask

    task automatic run_cycle(input string tg);
        logic [35:0] nl [3][2];
        logic [35:0] np [3][2];
        int rw [3][2];
        int lnx [3][2];
        string tags [3][2];
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 2; p++) begin
                rw[k][p]  = int'(ad[k][p]) / ln_of(WID[k][p]);
                lnx[k][p] = int'(ad[k][p]) % ln_of(WID[k][p]);
            end
            if (!SDPM[k] && en[k][0] && we[k][0] && en[k][1] && we[k][1] &&
                rw[k][0] == rw[k][1] &&
                ((place('0, WID[k][0], lnx[k][0], '1) & place('0, WID[k][1], lnx[k][1], '1)) != 0)) begin
                we[k][1] = 1'b0;
                flagged++;
            end
            for (int p = 0; p < 2; p++) begin
                bit cw = (p == 0) || !SDPM[k];
                bit cr = (p == 1) || !SDPM[k];
                bit pb = SDPM[k] && (p == 1) && en[k][0] && we[k][0];
                logic [35:0] old = take(mdl[k][rw[k][p]], WID[k][p], lnx[k][p]);
                nl[k][p] = lat[k][p];
                np[k][p] = lat[k][p];
                if (rst) begin
                    nl[k][p] = '0; np[k][p] = '0; tags[k][p] = "R9";
                end else if (en[k][p] && we[k][p] && cw) begin
                    if (cr) begin
                        if (MD[k][p] == WM_READ_FIRST) nl[k][p] = old;
                        else if (MD[k][p] == WM_WRITE_FIRST) nl[k][p] = di[k][p] & wmask(WID[k][p]);
                    end
                    tags[k][p] = SDPM[k] ? "R8" : (ORG[k][p] ? "R3" : "R4");
                end else if (en[k][p] && cr && !pb) begin
                    nl[k][p] = old;
                    tags[k][p] = SDPM[k] ? "R8" : (ORG[k][p] ? "R3" : "R1");
                end else begin
                    tags[k][p] = SDPM[k] ? "R8" : "R2";
                end
            end
            for (int p = 0; p < 2; p++) begin
                if (en[k][p] && we[k][p] && ((p == 0) || !SDPM[k]))
                    mdl[k][rw[k][p]] = place(mdl[k][rw[k][p]], WID[k][p], lnx[k][p], di[k][p]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 2; p++) begin
                logic [35:0] exp;
                logic [35:0] act;
                string t;
                lat[k][p] = nl[k][p];
                pip[k][p] = np[k][p];
                exp = ORG[k][p] ? pip[k][p] : lat[k][p];
                act = outp(k, p);
                t = (tg != "") ? tg : tags[k][p];
                checks++;
                if (act !== exp) begin
                    errors++;
                    $display("FAIL %s inst%0d port%0d: got %h expected %h", t, k, p, act, exp);
                end
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7321);
        for (int k = 0; k < 3; k++) begin
            for (int r = 0; r < 512; r++) mdl[k][r] = '0;
            for (int p = 0; p < 2; p++) begin lat[k][p] = '0; pip[k][p] = '0; end
        end
        idle();
        rst = 1'b1;
        @(negedge clk);
        run_cycle("R9");
        run_cycle("R9");
        rst = 1'b0;

        // R5: wide write then narrow lane reads
        idle(); put(0, 1, 1, 1, 3, 36'hA_8765_4321); run_cycle("R4");
        idle(); run_cycle("R3");
        idle(); put(0, 0, 1, 0, 24, 0); run_cycle("R5");
        idle(); put(0, 0, 1, 0, 31, 0); run_cycle("R5");
        // R7: narrow write read back through wide port
        idle(); put(0, 0, 1, 1, 26, 36'hF); run_cycle("R4");
        idle(); put(0, 1, 1, 0, 3, 0); run_cycle("R7");
        idle(); run_cycle("R7");
        // R6: parity from wide port is invisible to 4-bit lanes
        idle(); put(0, 1, 1, 1, 5, 36'hF_0000_0000); run_cycle("R6");
        for (int a = 40; a < 48; a++) begin
            idle(); put(0, 0, 1, 0, a, 0); run_cycle("R6");
        end
        // R6: 9-bit lane parity seen through 18-bit port
        idle(); put(1, 0, 1, 1, 29, 36'h1AB); run_cycle("R6");
        idle(); put(1, 1, 1, 0, 14, 0); run_cycle("R6");
        idle(); put(1, 1, 1, 0, 15, 0); run_cycle("R6");
        // R2: disabled port ignores write enable
        idle(); put(0, 0, 0, 1, 24, 36'h7); run_cycle("R2");
        idle(); put(0, 0, 1, 0, 24, 0); run_cycle("R2");
        // R7: same-cycle read of bits being written returns old contents
        idle(); put(0, 0, 1, 1, 0, 36'h5); put(0, 1, 1, 0, 0, 0); run_cycle("R7");
        idle(); run_cycle("R7");
        // R8: simple dual-port behaviour
        idle(); put(2, 0, 1, 1, 2, 36'hF_1234_5678); put(2, 1, 1, 0, 8, 0); run_cycle("R8");
        idle(); put(2, 1, 1, 1, 8, 36'h0); run_cycle("R8");
        idle(); put(2, 1, 1, 0, 11, 0); run_cycle("R8");
        // R4: no-change mode keeps previous output
        idle(); put(1, 0, 1, 0, 29, 0); run_cycle("R4");
        idle(); put(1, 0, 1, 1, 5, 36'h155); run_cycle("R4");
        idle(); run_cycle("R4");

        for (int n = 0; n < 3000; n++) begin
            rst = (n >= 1500 && n < 1502);
            for (int k = 0; k < 3; k++)
                for (int p = 0; p < 2; p++) begin
                    en[k][p] = !rst && (($urandom % 4) != 0);
                    we[k][p] = ($urandom % 5) < 2;
                    ad[k][p] = 14'($urandom % (512 * ln_of(WID[k][p])));
                    di[k][p] = {4'($urandom), 32'($urandom)} & wmask(WID[k][p]);
                end
            run_cycle("");
        end
        rst = 1'b0;
        $display("note: %0d overlapping same-cycle writes suppressed", flagged);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule